// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block is the cache controller that sits beside one processor in a small bus-based shared-memory system. It owns a direct-mapped write-back data cache with one data word per line. Each line is kept coherent with other caches by an invalidation protocol with three line states: Invalid (`LS_INV`, code 0), Shared (`LS_SHR`, code 1, clean and readable) and Exclusive (`LS_EXC`, code 2, the only copy, writable and dirty). The processor side uses a valid/ready handshake. The bus side requests an atomic one-cycle bus slot with `bus_req`/`bus_gnt` and issues one of three commands: read miss (`BC_RDMISS`, code 1), write miss (`BC_WRMISS`, code 2) or write-back (`BC_WBACK`, code 3).

The processor-side machine has five named states:
- `CS_IDLE` accepts a request (transition *accept*).
- `CS_CHECK` looks up the line. It stalls while a snoop is on the bus (*snoop stall*). It completes hits locally (*hit*), or goes to write back a dirty victim (*evict dirty*) or straight to the miss (*miss*).
- `CS_WBACK` writes the dirty victim to memory (*write-back done*). It skips to the miss when a snoop has already taken the victim (*victim lost*).
- `CS_MISS` places the read or write miss and fills the line from the bus (*fill*).
- `CS_RESP` raises `cpu_ready` for one cycle (*respond*) and returns to `CS_IDLE`.

The bus-side logic watches every slot that another controller owns. It invalidates a line on a matching write miss. It downgrades an Exclusive line to Shared on a matching read miss. Whenever the snooped line is Exclusive, it drives the dirty word on `snp_flush_data` and raises `snp_flush`. The bus then takes that word instead of the memory's reply and writes it into memory.

A line inspection port (`obs_idx` in, state/tag/data out) shows any line's contents. It exists so that the coherence state can be observed from outside.

Top module: `snoop_wb_cache`

## Requirements
- R1: After reset every line reads as state code 0 (Invalid), and `cpu_ready` and `bus_req` are low.
- R2: A read whose line is Invalid, or holds another tag, places a read miss (code 1) on the bus. The line becomes Shared (code 1) with the tag of the request and the word from `bus_fill`, and that word is returned on `cpu_rdata`.
- R3: A write to a line that is Invalid, holds another tag, or holds the same tag in Shared places a write miss (code 2) on the bus. The line becomes Exclusive (code 2) holding the written word.
- R4: A read hitting Shared or Exclusive, and a write hitting Exclusive, complete without any bus slot. The state is unchanged, and a write hit replaces the word.
- R5: A miss whose line is Exclusive under another tag first writes back (code 3) the old word to the address formed from the old tag and the index, and then issues its miss. A miss that evicts a Shared line issues no write-back.
- R6: A snooped write miss to an address held in Shared makes that line Invalid, without a flush.
- R7: A snooped write miss to an address held in Exclusive raises `snp_flush` with the dirty word, and the line becomes Invalid.
- R8: A snooped read miss to an address held in Exclusive raises `snp_flush` with the dirty word, and the line becomes Shared. A snooped read miss to a Shared line changes nothing.
- R9: A snoop changes nothing and raises no flush when the line at its index is Invalid or holds a different tag. An address with the same index but another tag is never treated as a hit. Address bits [IDX_W-1:0] are the index and the upper bits are the tag.
- R10: A pending processor request does not act on the cache while a snoop is valid. It stays pending until its bus work is done, and `cpu_ready` is a single-cycle pulse ending the request. Requests from two controllers on the same address are serialized, with the later writer ending Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line word, valid with `cpu_ready` |
| bus_req | output | 1 | Bus slot request |
| bus_gnt | input | 1 | Slot granted this cycle |
| bus_cmd | output | 2 | Command of the requested slot |
| bus_addr | output | ADDR_W | Address of the requested slot |
| bus_wdata | output | DATA_W | Write-back word |
| bus_fill | input | DATA_W | Reply word during a granted miss |
| snp_valid | input | 1 | Another controller owns the bus this cycle |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the word and memory's reply is aborted |
| snp_flush_data | output | DATA_W | Dirty word supplied |
| obs_idx | input | IDX_W | Line to inspect |
| obs_state | output | 2 | State code of inspected line |
| obs_tag | output | ADDR_W-IDX_W | Tag of inspected line |
| obs_data | output | DATA_W | Word of inspected line |

## Verification
The assertions assume that the bus is atomic and has one owner. `bus_gnt` is only given while `bus_req` is high, and `snp_valid` is never high in a cycle where this controller holds the grant. They also assume that `snp_cmd` is a defined command whenever `snp_valid` is high. The bench builds the bus from two controllers with a fixed-priority arbiter that grants at most one request per cycle. It feeds each controller's command to the other as its snoop. This keeps every slot exclusive, including the runs where both processors issue requests at the same time or one cycle apart.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_CHECK = 3'd1,
        CS_WBACK = 3'd2,
        CS_MISS  = 3'd3,
        CS_RESP  = 3'd4
    } ctl_st_e;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor-side read port
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    // snoop-side read port
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    // inspection read port
    input  logic [IDX_W-1:0]  c_idx,
    output line_st_e          c_st,
    output logic [TAG_W-1:0]  c_tag,
    output logic [DATA_W-1:0] c_data,
    // processor-side full line write
    input  logic              own_we,
    input  logic [IDX_W-1:0]  own_idx,
    input  line_st_e          own_st,
    input  logic [TAG_W-1:0]  own_tag,
    input  logic [DATA_W-1:0] own_data,
    // snoop-side state write (wins over own write)
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  line_st_e          snp_st
);

    localparam int NLINES = 1 << IDX_W;

    line_st_e          st_q  [NLINES];
    logic [TAG_W-1:0]  tag_q [NLINES];
    logic [DATA_W-1:0] dat_q [NLINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (snp_we && snp_idx == IDX_W'(i)) begin
                    st_q[i] <= snp_st;
                end else if (own_we && own_idx == IDX_W'(i)) begin
                    st_q[i]  <= own_st;
                    tag_q[i] <= own_tag;
                    dat_q[i] <= own_data;
                end
            end
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = dat_q[b_idx];
    assign c_st   = st_q[c_idx];
    assign c_tag  = tag_q[c_idx];
    assign c_data = dat_q[c_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output line_st_e          upd_st,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data
);

    logic match;

    assign match      = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
    assign flush_data = line_data;

    always_comb begin
        upd_en = 1'b0;
        upd_st = line_st;
        flush  = 1'b0;
        if (match) begin
            unique case (snp_cmd)
                BC_RDMISS: begin
                    // dirty owner supplies the word and keeps a clean copy
                    if (line_st == LS_EXC) begin
                        upd_en = 1'b1;
                        upd_st = LS_SHR;
                        flush  = 1'b1;
                    end
                end
                BC_WRMISS: begin
                    upd_en = 1'b1;
                    upd_st = LS_INV;
                    flush  = (line_st == LS_EXC);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coh_cpu_ctrl.sv
module coh_cpu_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic                    snp_busy,
    output logic [IDX_W-1:0]        line_idx,
    input  line_st_e                line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output bus_cmd_e                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic [DATA_W-1:0]       bus_fill,
    output logic                    own_we,
    output line_st_e                own_st,
    output logic [ADDR_W-IDX_W-1:0] own_tag,
    output logic [DATA_W-1:0]       own_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_e            state_q, state_d;
    logic               req_we_q;
    logic [ADDR_W-1:0]  req_addr_q;
    logic [DATA_W-1:0]  req_wdata_q;
    logic [TAG_W-1:0]   req_tag;
    logic               tag_hit, local_done, victim_dirty;

    assign req_tag      = req_addr_q[ADDR_W-1:IDX_W];
    assign line_idx     = req_addr_q[IDX_W-1:0];
    assign tag_hit      = (line_st != LS_INV) && (line_tag == req_tag);
    assign local_done   = tag_hit && (!req_we_q || line_st == LS_EXC);
    assign victim_dirty = (line_st == LS_EXC) && (line_tag != req_tag);

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= CS_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CS_IDLE && cpu_valid) begin
                req_we_q    <= cpu_we;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:  if (cpu_valid) state_d = CS_CHECK;
            CS_CHECK: begin
                if (snp_busy)          state_d = CS_CHECK;
                else if (local_done)   state_d = CS_RESP;
                else if (victim_dirty) state_d = CS_WBACK;
                else                   state_d = CS_MISS;
            end
            CS_WBACK: if (!victim_dirty || bus_gnt) state_d = CS_MISS;
            CS_MISS:  if (bus_gnt) state_d = CS_RESP;
            CS_RESP:  state_d = CS_IDLE;
            default:  state_d = CS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = req_addr_q;
        bus_wdata = req_wdata_q;
        own_we    = 1'b0;
        own_st    = line_st;
        own_tag   = line_tag;
        own_data  = line_data;
        unique case (state_q)
            CS_IDLE: ;
            CS_CHECK: begin
                if (!snp_busy && local_done && req_we_q) begin
                    own_we   = 1'b1;
                    own_data = req_wdata_q;
                end
            end
            CS_WBACK: begin
                bus_req   = victim_dirty;
                bus_cmd   = BC_WBACK;
                bus_addr  = {line_tag, line_idx};
                bus_wdata = line_data;
                if (victim_dirty && bus_gnt) begin
                    own_we = 1'b1;
                    own_st = LS_INV;
                end
            end
            CS_MISS: begin
                bus_req = 1'b1;
                bus_cmd = req_we_q ? BC_WRMISS : BC_RDMISS;
                if (bus_gnt) begin
                    own_we   = 1'b1;
                    own_tag  = req_tag;
                    own_st   = req_we_q ? LS_EXC : LS_SHR;
                    own_data = req_we_q ? req_wdata_q : bus_fill;
                end
            end
            CS_RESP: begin
                cpu_ready = 1'b1;
                cpu_rdata = line_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/snoop_wb_cache.sv
module snoop_wb_cache
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic [1:0]              bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic [DATA_W-1:0]       bus_fill,
    input  logic                    snp_valid,
    input  logic [1:0]              snp_cmd,
    input  logic [ADDR_W-1:0]       snp_addr,
    output logic                    snp_flush,
    output logic [DATA_W-1:0]       snp_flush_data,
    input  logic [IDX_W-1:0]        obs_idx,
    output logic [1:0]              obs_state,
    output logic [ADDR_W-IDX_W-1:0] obs_tag,
    output logic [DATA_W-1:0]       obs_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx;
    line_st_e          a_st, b_st, c_st, own_st, snp_upd_st;
    logic [TAG_W-1:0]  a_tag, b_tag, own_tag;
    logic [DATA_W-1:0] a_data, b_data, own_data;
    logic              own_we, snp_upd_en;
    bus_cmd_e          bus_cmd_e_w;

    coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (a_idx),
        .a_st     (a_st),
        .a_tag    (a_tag),
        .a_data   (a_data),
        .b_idx    (snp_addr[IDX_W-1:0]),
        .b_st     (b_st),
        .b_tag    (b_tag),
        .b_data   (b_data),
        .c_idx    (obs_idx),
        .c_st     (c_st),
        .c_tag    (obs_tag),
        .c_data   (obs_data),
        .own_we   (own_we),
        .own_idx  (a_idx),
        .own_st   (own_st),
        .own_tag  (own_tag),
        .own_data (own_data),
        .snp_we   (snp_upd_en),
        .snp_idx  (snp_addr[IDX_W-1:0]),
        .snp_st   (snp_upd_st)
    );

    coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_e'(snp_cmd)),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .line_st    (b_st),
        .line_tag   (b_tag),
        .line_data  (b_data),
        .upd_en     (snp_upd_en),
        .upd_st     (snp_upd_st),
        .flush      (snp_flush),
        .flush_data (snp_flush_data)
    );

    coh_cpu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .snp_busy  (snp_valid),
        .line_idx  (a_idx),
        .line_st   (a_st),
        .line_tag  (a_tag),
        .line_data (a_data),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_cmd   (bus_cmd_e_w),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_fill  (bus_fill),
        .own_we    (own_we),
        .own_st    (own_st),
        .own_tag   (own_tag),
        .own_data  (own_data)
    );

    assign bus_cmd   = bus_cmd_e_w;
    assign obs_state = c_st;

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_flush
);

    // R7 / R8: a flush only answers a snooped miss
    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    // R10: completion is a one-cycle pulse
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R10: an ungranted request holds its command and address
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R5: a granted write-back is followed by the miss request
    p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == 2'd3) |=> (bus_req && bus_cmd != 2'd3));

    // R2 / R3: a granted miss completes on the next cycle
    p_miss_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && (bus_cmd == 2'd1 || bus_cmd == 2'd2)) |=> cpu_ready);

    // R4: no bus request while answering the processor
    p_quiet_on_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

endmodule

bind snoop_wb_cache coh_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_flush (snp_flush)
);

// File: tb/snoop_wb_cache_tb_top.sv
`timescale 1ns/1ps
module snoop_wb_cache_tb_top;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int IW = 2;
    localparam int TW = AW - IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_bus = 0;
    int n_wb = 0;

    logic          c0_valid = 0, c0_we = 0, c1_valid = 0, c1_we = 0;
    logic [AW-1:0] c0_addr = 0, c1_addr = 0;
    logic [DW-1:0] c0_wdata = 0, c1_wdata = 0;
    logic          c0_ready, c1_ready;
    logic [DW-1:0] c0_rdata, c1_rdata;
    logic          req0, req1, gnt0, gnt1;
    logic [1:0]    cmd0, cmd1;
    logic [AW-1:0] addr0, addr1;
    logic [DW-1:0] wd0, wd1, fill0, fill1;
    logic          fl0, fl1;
    logic [DW-1:0] fd0, fd1;
    logic [IW-1:0] o0_idx = 0, o1_idx = 0;
    logic [1:0]    o0_st, o1_st;
    logic [TW-1:0] o0_tag, o1_tag;
    logic [DW-1:0] o0_dat, o1_dat;

    logic [DW-1:0] mem [1 << AW];

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a ^ 8'h5A);
    endfunction

    // fixed-priority arbiter: one owner per cycle
    assign gnt0  = req0;
    assign gnt1  = req1 && !req0;
    assign fill0 = fl1 ? fd1 : mem[addr0];
    assign fill1 = fl0 ? fd0 : mem[addr1];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < (1 << AW); a++) mem[a] <= init_val(a);
        end else begin
            if (gnt0 || gnt1) n_bus <= n_bus + 1;
            if (gnt0) begin
                if (cmd0 == 2'd3) begin mem[addr0] <= wd0; n_wb <= n_wb + 1; end
                if (fl1) mem[addr0] <= fd1;
            end
            if (gnt1) begin
                if (cmd1 == 2'd3) begin mem[addr1] <= wd1; n_wb <= n_wb + 1; end
                if (fl0) mem[addr1] <= fd0;
            end
        end
    end

    snoop_wb_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(c0_valid), .cpu_we(c0_we), .cpu_addr(c0_addr), .cpu_wdata(c0_wdata),
        .cpu_ready(c0_ready), .cpu_rdata(c0_rdata),
        .bus_req(req0), .bus_gnt(gnt0), .bus_cmd(cmd0), .bus_addr(addr0),
        .bus_wdata(wd0), .bus_fill(fill0),
        .snp_valid(gnt1), .snp_cmd(cmd1), .snp_addr(addr1),
        .snp_flush(fl0), .snp_flush_data(fd0),
        .obs_idx(o0_idx), .obs_state(o0_st), .obs_tag(o0_tag), .obs_data(o0_dat)
    );

    snoop_wb_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) peer_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(c1_valid), .cpu_we(c1_we), .cpu_addr(c1_addr), .cpu_wdata(c1_wdata),
        .cpu_ready(c1_ready), .cpu_rdata(c1_rdata),
        .bus_req(req1), .bus_gnt(gnt1), .bus_cmd(cmd1), .bus_addr(addr1),
        .bus_wdata(wd1), .bus_fill(fill1),
        .snp_valid(gnt0), .snp_cmd(cmd0), .snp_addr(addr0),
        .snp_flush(fl1), .snp_flush_data(fd1),
        .obs_idx(o1_idx), .obs_state(o1_st), .obs_tag(o1_tag), .obs_data(o1_dat)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // state 0/1/2 = Invalid/Shared/Exclusive; tag/data only compared when valid
    task automatic chk_line(input string req, input int p, input int idx,
                            input int st, input int tag, input int dat);
        if (p == 0) o0_idx = IW'(idx); else o1_idx = IW'(idx);
        #1;
        check(req, $sformatf("P%0d line%0d state", p + 1, idx), p == 0 ? o0_st : o1_st, st);
        if (st != 0) begin
            check(req, $sformatf("P%0d line%0d tag", p + 1, idx), p == 0 ? o0_tag : o1_tag, tag);
            check(req, $sformatf("P%0d line%0d data", p + 1, idx), p == 0 ? o0_dat : o1_dat, dat);
        end
    endtask

    task automatic chk_mem(input string req, input int a, input int exp);
        check(req, $sformatf("mem[%0d]", a), mem[a], exp);
    endtask

    task automatic cpu_op(input int p, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd);
        rd = 'x;
        @(negedge clk);
        if (p == 0) begin c0_valid = 1; c0_we = we; c0_addr = a; c0_wdata = d; end
        else        begin c1_valid = 1; c1_we = we; c1_addr = a; c1_wdata = d; end
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if ((p == 0) ? c0_ready : c1_ready) begin
                rd = (p == 0) ? c0_rdata : c1_rdata;
                break;
            end
        end
        if (p == 0) c0_valid = 0; else c1_valid = 0;
    endtask

    function automatic int tg(input int a);
        return a >> IW;
    endfunction

    function automatic void summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    localparam int A1 = 8'h10;
    localparam int A2 = 8'h20;
    localparam int A3 = 8'h30;

    initial begin
        logic [DW-1:0] rd, rd2;
        int b0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            chk_line("R1", 0, i, 0, 0, 0);
            chk_line("R1", 1, i, 0, 0, 0);
        end
        check("R1", "ready/req idle", {c0_ready, c1_ready, req0, req1}, 0);

        // step 1: P1 writes 10 to A1 (write miss from Invalid)
        cpu_op(0, 1, A1, 10, rd);
        chk_line("R3", 0, 0, 2, tg(A1), 10);
        chk_line("R3", 1, 0, 0, 0, 0);
        chk_mem("R3", A1, init_val(A1));

        // step 2: P1 reads A1 (local hit in Exclusive)
        b0 = n_bus;
        cpu_op(0, 0, A1, 0, rd);
        check("R4", "read hit data", rd, 10);
        check("R4", "bus slots on hit", n_bus - b0, 0);
        chk_line("R4", 0, 0, 2, tg(A1), 10);
        chk_line("R4", 1, 0, 0, 0, 0);
        chk_mem("R4", A1, init_val(A1));

        // step 3: P2 reads A1 (P1 flushes, goes Shared)
        cpu_op(1, 0, A1, 0, rd);
        check("R8", "P2 read data", rd, 10);
        chk_line("R8", 0, 0, 1, tg(A1), 10);
        chk_line("R2", 1, 0, 1, tg(A1), 10);
        chk_mem("R8", A1, 10);

        // step 4: P2 writes 20 to A1 (Shared write -> write miss, P1 invalidated)
        b0 = n_bus;
        cpu_op(1, 1, A1, 20, rd);
        check("R3", "bus slots on shared write", n_bus - b0, 1);
        chk_line("R6", 0, 0, 0, 0, 0);
        chk_line("R3", 1, 0, 2, tg(A1), 20);
        chk_mem("R6", A1, 10);

        // step 5: P2 writes 40 to A2 (dirty eviction of A1 first)
        w0 = n_wb;
        cpu_op(1, 1, A2, 40, rd);
        check("R5", "write-backs", n_wb - w0, 1);
        chk_line("R9", 0, 0, 0, 0, 0);
        chk_line("R5", 1, 0, 2, tg(A2), 40);
        chk_mem("R5", A1, 20);
        chk_mem("R5", A2, init_val(A2));

        // P1 reads A2: P2 flushes 40 and keeps Shared
        cpu_op(0, 0, A2, 0, rd);
        check("R2", "P1 read data", rd, 40);
        chk_line("R2", 0, 0, 1, tg(A2), 40);
        chk_line("R8", 1, 0, 1, tg(A2), 40);
        chk_mem("R8", A2, 40);

        // P1 reads A3: clean eviction, P2 tag differs and stays
        w0 = n_wb;
        cpu_op(0, 0, A3, 0, rd);
        check("R2", "P1 read A3", rd, init_val(A3));
        check("R5", "no write-back for clean victim", n_wb - w0, 0);
        chk_line("R2", 0, 0, 1, tg(A3), init_val(A3));
        chk_line("R9", 1, 0, 1, tg(A2), 40);

        // P2 writes 50 to A2 from Shared; P1 holds another tag
        cpu_op(1, 1, A2, 50, rd);
        chk_line("R9", 0, 0, 1, tg(A3), init_val(A3));
        chk_line("R3", 1, 0, 2, tg(A2), 50);

        // P1 writes 60 to A2: P2 Exclusive flushes and invalidates
        cpu_op(0, 1, A2, 60, rd);
        chk_line("R7", 1, 0, 0, 0, 0);
        chk_line("R7", 0, 0, 2, tg(A2), 60);
        chk_mem("R7", A2, 50);

        // P1 write hit in Exclusive
        b0 = n_bus;
        cpu_op(0, 1, A2, 61, rd);
        check("R4", "bus slots on write hit", n_bus - b0, 0);
        chk_line("R4", 0, 0, 2, tg(A2), 61);

        // sweep of the other indices with two tags each
        for (int idx = 1; idx < 4; idx++) begin
            for (int t = 1; t <= 2; t++) begin
                int a, v;
                a = (t << IW) | idx;
                v = idx * 16 + t;
                cpu_op(1, 1, AW'(a), DW'(v), rd);
                chk_line("R3", 1, idx, 2, t, v);
                cpu_op(0, 0, AW'(a), 0, rd);
                check("R2", $sformatf("sweep read %0d", a), rd, v);
                chk_line("R8", 1, idx, 1, t, v);
                chk_line("R2", 0, idx, 1, t, v);
                chk_mem("R8", a, v);
            end
        end

        // simultaneous writes to the same address: serialized by the bus
        fork
            cpu_op(0, 1, 8'h45, 8'h77, rd);
            cpu_op(1, 1, 8'h45, 8'h88, rd2);
        join
        chk_line("R10", 0, 1, 0, 0, 0);
        chk_line("R10", 1, 1, 2, 8'h45 >> IW, 8'h88);
        chk_mem("R10", 8'h45, 8'h77);

        // P2 read hit issued while P1's miss owns the bus
        fork
            cpu_op(0, 0, 8'h45, 0, rd);
            begin @(negedge clk); cpu_op(1, 0, 8'h45, 0, rd2); end
        join
        check("R10", "P1 read during stall", rd, 8'h88);
        check("R10", "P2 read after stall", rd2, 8'h88);
        chk_line("R10", 1, 1, 1, 8'h45 >> IW, 8'h88);
        chk_line("R8", 0, 1, 1, 8'h45 >> IW, 8'h88);
        chk_mem("R8", 8'h45, 8'h88);

        summary();
        $finish;
    end

endmodule